// File: doc/BRIEF.md
# Noise-Shaped Fractional Clock Divider

This block turns a free-running reference clock into a periodic one-cycle enable pulse. The divisor has an integer part and a 12-bit fraction, so the average output period is integer + fraction/4096 reference cycles. It reaches that average by making some output periods one cycle longer or shorter than others. A two-bit mode field chooses how those corrections are spread. Mode 0 is integer-only division and discards the fraction. Modes 1, 2 and 3 are first-, second- and third-order noise-shaped accumulator cascades. They push the dithering error toward high frequencies at the cost of a wider spread of period lengths.

Software writes a control word and a divider word. The control word holds a run bit at bit 4 and the mode field at bits 10:9. The divider word holds the fraction in bits 11:0 and the integer part from bit 12 upward, so 0x13333 means 19 + 819/4096. A new divider or mode value takes effect at the next period boundary. A running period is therefore never cut short. Clearing the run bit silences the output and returns the accumulators to zero.

Top module: `fracClkDiv`

## Requirements
- R1: In mode 0 the fraction bits (divider bits 11:0) are ignored: every output period lasts exactly the integer part (divider bits 23:12), after clamping, in reference cycles.
- R2: In mode 1 the first 4096 periods after start sum to integer*4096 + fraction cycles, and every period is integer or integer+1 cycles long.
- R3: In mode 2 the first 4096 periods after start sum to integer*4096 + fraction cycles, and every period lies between integer-1 and integer+2 cycles.
- R4: In mode 3 the first 4096 periods after start sum to within one cycle of integer*4096 + fraction, and every period lies between integer-3 and integer+4 cycles.
- R5: The integer part is raised to a mode-dependent minimum: 2 in modes 0 and 1, 3 in mode 2, 5 in mode 3. The output pulse is therefore never high in two consecutive cycles.
- R6: A divider write never alters the period in progress. If the write lands in the last cycle of a period (the pulse cycle), the next period still uses the old value, and the value written applies from the period after that.
- R7: Writing the control word with bit 4 set starts division: the first pulse appears L+1 cycles after the write cycle, where L is the first period length. Writing bit 4 clear forces the pulse low from the next cycle and zeroes the accumulators, so a restart repeats the sequence from its beginning.
- R8: The busy output is low during reset and whenever the divider is stopped. It is high while the divider runs, and the pulse is only ever high while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWord | input | 16 | Control word: bit 4 run, bits 10:9 mode |
| divWe | input | 1 | Divider word write strobe |
| divWord | input | 24 | Divider: bits 23:12 integer, bits 11:0 fraction |
| outTick | output | 1 | One-cycle pulse marking the end of each output period |
| busy | output | 1 | High while the divider is running |

## Verification
A divider write and a period boundary can fall in the same cycle. The bench provokes this by driving the write exactly in the cycle where the pulse is high. It then expects the period that starts at that edge to keep the old length, and the one after it to take the new one. The same measurement, with the write placed three cycles into a period, confirms that a mid-period write does not shorten the running period. Long runs of 4096 periods per mode are compared against the integer*4096 + fraction total and the per-mode length spread.

// File: rtl/fracDivPkg.sv
package fracDivPkg;

  localparam int RUN_BIT  = 4;
  localparam int MODE_LSB = 9;

  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_ORD1 = 2'd1,
    MODE_ORD2 = 2'd2,
    MODE_ORD3 = 2'd3
  } shapeMode_t;

  typedef struct packed {
    logic step;
    logic clear;
  } dpStrb_t;

  function automatic int unsigned minInteger(input logic [1:0] mode);
    case (mode)
      MODE_ORD2: return 3;
      MODE_ORD3: return 5;
      default:   return 2;
    endcase
  endfunction

endpackage

// File: rtl/mashDp.sv
module mashDp
  import fracDivPkg::*;
#(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [FRAC_W-1:0] fracIn,
  input  logic [1:0]        modeSel,
  output logic signed [3:0] delta
);

  localparam int STAGES = 3;

  logic [FRAC_W-1:0] acc [STAGES];
  logic [FRAC_W-1:0] nxt [STAGES];
  logic [STAGES-1:0] carry;
  logic              c2Dly, c3Dly, c3Dly2;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [FRAC_W:0] sum;
    if (s == 0) begin : g_head
      assign sum = {1'b0, acc[s]} + {1'b0, fracIn};
    end else begin : g_tail
      assign sum = {1'b0, acc[s]} + {1'b0, nxt[s-1]};
    end
    assign nxt[s]   = sum[FRAC_W-1:0];
    assign carry[s] = sum[FRAC_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           acc[s] <= '0;
      else if (strb.clear) acc[s] <= '0;
      else if (strb.step)  acc[s] <= nxt[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c2Dly  <= 1'b0;
      c3Dly  <= 1'b0;
      c3Dly2 <= 1'b0;
    end else if (strb.clear) begin
      c2Dly  <= 1'b0;
      c3Dly  <= 1'b0;
      c3Dly2 <= 1'b0;
    end else if (strb.step) begin
      c2Dly  <= carry[1];
      c3Dly  <= carry[2];
      c3Dly2 <= c3Dly;
    end
  end

  logic signed [3:0] d1, d2, d3;

  always_comb begin
    d1 = $signed({3'b000, carry[0]});
    d2 = $signed({3'b000, carry[1]}) - $signed({3'b000, c2Dly});
    d3 = $signed({3'b000, carry[2]}) - $signed({2'b00, c3Dly, 1'b0})
       + $signed({3'b000, c3Dly2});
    case (modeSel)
      MODE_ORD1: delta = d1;
      MODE_ORD2: delta = d1 + d2;
      MODE_ORD3: delta = d1 + d2 + d3;
      default:   delta = 4'sd0;
    endcase
  end

endmodule

// File: rtl/divCtl.sv
module divCtl
  import fracDivPkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 12,
  parameter int CTRL_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ctrlWe,
  input  logic [CTRL_W-1:0]       ctrlWord,
  input  logic                    divWe,
  input  logic [INT_W+FRAC_W-1:0] divWord,
  input  logic signed [3:0]       delta,
  output dpStrb_t                 strb,
  output logic [FRAC_W-1:0]       fracEff,
  output logic [1:0]              modeSel,
  output logic                    outTick,
  output logic                    busy
);

  localparam int DIV_W = INT_W + FRAC_W;
  localparam int CNT_W = INT_W + 1;

  logic             runEn;
  logic [1:0]       modeR;
  logic [DIV_W-1:0] divR;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [INT_W-1:0] intField, intFloor, intEff;
  logic [CNT_W-1:0] lenNext;
  logic             boundary;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn <= 1'b0;
      modeR <= MODE_INT;
    end else if (ctrlWe) begin
      runEn <= ctrlWord[RUN_BIT];
      modeR <= ctrlWord[MODE_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      divR <= '0;
    else if (divWe) divR <= divWord;
  end

  always_comb begin
    intField = divR[DIV_W-1:FRAC_W];
    intFloor = INT_W'(minInteger(modeR));
    intEff   = (intField < intFloor) ? intFloor : intField;
    lenNext  = CNT_W'(intEff) + {{(CNT_W-4){delta[3]}}, delta};
    boundary = runEn && (!running || cnt == CNT_W'(1));
    strb.step  = boundary;
    strb.clear = !runEn;
    fracEff  = (modeR == MODE_INT) ? '0 : divR[FRAC_W-1:0];
    modeSel  = modeR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!runEn) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (boundary) begin
      running <= 1'b1;
      cnt     <= lenNext;
    end else begin
      cnt     <= cnt - CNT_W'(1);
    end
  end

  assign outTick = running && runEn && (cnt == CNT_W'(1));
  assign busy    = running;

endmodule

// File: rtl/fracClkDiv.sv
module fracClkDiv
  import fracDivPkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 12,
  parameter int CTRL_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ctrlWe,
  input  logic [CTRL_W-1:0]       ctrlWord,
  input  logic                    divWe,
  input  logic [INT_W+FRAC_W-1:0] divWord,
  output logic                    outTick,
  output logic                    busy
);

  dpStrb_t           strb;
  logic [FRAC_W-1:0] fracEff;
  logic [1:0]        modeSel;
  logic signed [3:0] delta;

  divCtl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .CTRL_W(CTRL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWord(ctrlWord),
    .divWe(divWe), .divWord(divWord), .delta(delta), .strb(strb),
    .fracEff(fracEff), .modeSel(modeSel), .outTick(outTick), .busy(busy)
  );

  mashDp #(.FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fracIn(fracEff),
    .modeSel(modeSel), .delta(delta)
  );

endmodule

// File: rtl/fracClkDivChk.sv
module fracClkDivChk
  import fracDivPkg::*;
#(
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWe,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic              outTick,
  input logic              busy,
  input logic              stepStrb,
  input logic [1:0]        modeSel,
  input logic signed [3:0] delta
);

  AST_TICK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    outTick |-> busy); // R8

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    outTick |=> !outTick); // R5

  AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && !ctrlWord[RUN_BIT]) |=> !outTick); // R7

  AST_INT_MODE_FLAT: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrb && modeSel == MODE_INT) |-> delta == 4'sd0); // R1

  AST_ORD1_SPREAD: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrb && modeSel == MODE_ORD1) |-> (delta == 4'sd0 || delta == 4'sd1)); // R2

  AST_ORD2_SPREAD: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrb && modeSel == MODE_ORD2) |-> (delta >= -4'sd1 && delta <= 4'sd2)); // R3

  AST_ORD3_SPREAD: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrb && modeSel == MODE_ORD3) |-> (delta >= -4'sd3 && delta <= 4'sd4)); // R4

endmodule

bind fracClkDiv fracClkDivChk #(.CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWord(ctrlWord),
  .outTick(outTick), .busy(busy), .stepStrb(strb.step),
  .modeSel(modeSel), .delta(delta)
);

// File: tb/fracClkDiv_bench.sv
`timescale 1ns/1ps
module fracClkDiv_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [15:0] ctrlWord = '0;
  logic        divWe = 1'b0;
  logic [23:0] divWord = '0;
  logic        outTick, busy;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fracClkDiv u_fracClkDiv (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWord(ctrlWord),
    .divWe(divWe), .divWord(divWord), .outTick(outTick), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic en, input logic [1:0] mode);
    ctrlWord = '0;
    ctrlWord[4] = en;
    ctrlWord[10:9] = mode;
    ctrlWe = 1'b1;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic writeDiv(input int intPart, input int frac);
    divWord = {intPart[11:0], frac[11:0]};
    divWe = 1'b1;
    @(negedge clk);
    divWe = 1'b0;
  endtask

  // Called right after the start write; cycle 1 is the negedge after the write edge.
  task automatic runWindow(input int n, output int total, output int mn, output int mx);
    int cyc, prev, got, len;
    cyc = 1; prev = 1; got = 0; mn = 1 << 30; mx = 0;
    while (got < n && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (outTick) begin
        len = cyc - prev;
        prev = cyc;
        if (len < mn) mn = len;
        if (len > mx) mx = len;
        got++;
      end
    end
    total = prev - 1;
  endtask

  task automatic stopAndLoad(input int intPart, input int frac);
    writeCtrl(1'b0, 2'd0);
    @(negedge clk);
    writeDiv(intPart, frac);
  endtask

  task automatic waitTick();
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!outTick && guard < 1000);
  endtask

  // Starts at a pulse cycle; writes divider at cycle offset, returns the two following gaps.
  task automatic gapsWithWrite(input int offset, input int newInt, output int g1, output int g2);
    int cyc, got;
    cyc = 0; got = 0; g1 = 0; g2 = 0;
    while (got < 2 && cyc < 1000) begin
      if (cyc == offset) begin
        divWord = {newInt[11:0], 12'd0};
        divWe = 1'b1;
      end
      @(negedge clk);
      divWe = 1'b0;
      cyc++;
      if (outTick) begin
        if (got == 0) g1 = cyc;
        else g2 = cyc - g1;
        got++;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    int tot, mn, mx, g1, g2, ideal, diff;
    bit sawTick;

    repeat (3) @(negedge clk);
    check(outTick == 1'b0, "R8 reset pulse", outTick, 0);
    check(busy == 1'b0, "R8 reset busy", busy, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: mode 0 ignores the fraction
    writeDiv(5, 819);
    writeCtrl(1'b1, 2'd0);
    runWindow(4096, tot, mn, mx);
    check(tot == 20480, "R1 mode0 total", tot, 20480);
    check(mn == 5 && mx == 5, "R1 mode0 period", mx, 5);
    check(busy == 1'b1, "R8 busy while running", busy, 1);

    // R7: stop silences the output and drops busy
    writeCtrl(1'b0, 2'd0);
    sawTick = 1'b0;
    repeat (20) begin
      if (outTick) sawTick = 1'b1;
      @(negedge clk);
    end
    check(!sawTick, "R7 pulse low after stop", sawTick, 0);
    check(busy == 1'b0, "R8 busy low after stop", busy, 0);

    // R2: first order
    writeDiv(5, 819);
    writeCtrl(1'b1, 2'd1);
    runWindow(4096, tot, mn, mx);
    check(tot == 5 * 4096 + 819, "R2 mode1 total", tot, 5 * 4096 + 819);
    check(mn >= 5 && mx <= 6, "R2 mode1 spread", mx, 6);
    check(mn == 5 && mx == 6, "R2 mode1 both lengths", mn * 10 + mx, 56);

    // R3: second order
    stopAndLoad(5, 819);
    writeCtrl(1'b1, 2'd2);
    runWindow(4096, tot, mn, mx);
    check(tot == 5 * 4096 + 819, "R3 mode2 total", tot, 5 * 4096 + 819);
    check(mn >= 4 && mx <= 7, "R3 mode2 spread", mn * 10 + mx, 47);

    // R4: third order
    stopAndLoad(6, 819);
    writeCtrl(1'b1, 2'd3);
    runWindow(4096, tot, mn, mx);
    ideal = 6 * 4096 + 819;
    diff = tot - ideal;
    check(diff >= -1 && diff <= 1, "R4 mode3 total", tot, ideal);
    check(mn >= 3 && mx <= 10, "R4 mode3 spread", mn * 100 + mx, 310);

    // R5: clamping per mode
    stopAndLoad(0, 100);
    writeCtrl(1'b1, 2'd0);
    runWindow(16, tot, mn, mx);
    check(tot == 32 && mn == 2 && mx == 2, "R5 mode0 floor 2", tot, 32);
    stopAndLoad(1, 0);
    writeCtrl(1'b1, 2'd1);
    runWindow(16, tot, mn, mx);
    check(tot == 32 && mn == 2 && mx == 2, "R5 mode1 floor 2", tot, 32);
    stopAndLoad(1, 0);
    writeCtrl(1'b1, 2'd2);
    runWindow(16, tot, mn, mx);
    check(tot == 48 && mn == 3 && mx == 3, "R5 mode2 floor 3", tot, 48);
    stopAndLoad(2, 0);
    writeCtrl(1'b1, 2'd3);
    runWindow(16, tot, mn, mx);
    check(tot == 80 && mn == 5 && mx == 5, "R5 mode3 floor 5", tot, 80);
    stopAndLoad(0, 3000);
    writeCtrl(1'b1, 2'd3);
    runWindow(64, tot, mn, mx);
    check(mn >= 2 && mx <= 9, "R5 mode3 floor with fraction", mn, 2);

    // R6: mid-period write
    stopAndLoad(10, 0);
    writeCtrl(1'b1, 2'd0);
    waitTick();
    gapsWithWrite(3, 4, g1, g2);
    check(g1 == 10, "R6 mid write keeps running period", g1, 10);
    check(g2 == 4, "R6 mid write next period", g2, 4);

    // R6: write in the pulse cycle
    stopAndLoad(6, 0);
    writeCtrl(1'b1, 2'd0);
    waitTick();
    gapsWithWrite(0, 3, g1, g2);
    check(g1 == 6, "R6 boundary write old length", g1, 6);
    check(g2 == 3, "R6 boundary write new length", g2, 3);

    // R7: restart clears accumulators (lengths 2,3,2,3,...)
    stopAndLoad(2, 2048);
    writeCtrl(1'b1, 2'd1);
    runWindow(3, tot, mn, mx);
    check(tot == 7, "R7 first three periods", tot, 7);
    writeCtrl(1'b0, 2'd1);
    @(negedge clk);
    writeCtrl(1'b1, 2'd1);
    runWindow(1, tot, mn, mx);
    check(tot == 2, "R7 restart from zero state", tot, 2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule